// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Interrupt Detection

This block is an eight-pin general-purpose I/O port on a simple memory-mapped register bus. The bus is APB-style: select, enable, write strobe, address, write data and read data. Each pin can be an input or an output, set by a direction register. The pad side has three buses: the output value, the output enable and the raw input. Every pad input passes through a two-flop synchroniser before any logic uses it.

The data port takes a mask from the address of each access. A byte address in the data window selects pin n when address bit n+2 is set. Software can therefore read or change any group of pins with one access and no read-modify-write.

Each pin has its own interrupt detector. Three orthogonal configuration bits pick the trigger:
- level or edge;
- rising/high or falling/low;
- either edge, which overrides the polarity bit.

An edge sets a sticky status bit, which software clears by writing a one to it. In level mode the status bit follows the synchronised level and cannot be cleared. The status is ANDed with a per-pin enable mask. The OR of the masked bits drives the single interrupt output.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset the direction, output value, interrupt configuration, enable mask and spare register all read 0. `pin_oe_o`, `pin_o` and `irq_o` are all 0.
- R2: A read in the data window (byte address 0x000 to 0x3FC, address bits [11:10] = 0) returns a pin value only where its mask bit is set; all other bits read 0. The mask bit for pin n is address bit n+2, so 0x3FC selects all pins. An output pin returns its driven value. An input pin returns its synchronised pad value.
- R3: A write in the data window changes `pin_o` only for pins whose address mask bit is set. All other output bits keep their value.
- R4: The direction register is at byte address 0x400 and is readable. A 1 in bit n makes pin n an output, and `pin_oe_o` equals this register.
- R5: The level register (0x404, 1 = level), any-edge register (0x408, 1 = both edges) and polarity register (0x40C, 1 = rising or high) set the trigger. With level=0, any-edge=0 and polarity=1, a rising input sets the raw status bit and a falling input does not.
- R6: With level=0, any-edge=0 and polarity=0, a falling input sets the raw status bit and a rising input does not.
- R7: With level=0 and any-edge=1, both rising and falling inputs set the raw status bit, whatever the polarity bit holds.
- R8: With level=1, the raw status bit equals the synchronised pin when polarity=1 and its inverse when polarity=0. A clear write does not change it.
- R9: The enable mask is at 0x410. Raw status reads at 0x414 and masked status (raw AND mask) reads at 0x418. `irq_o` is 1 exactly when some masked status bit is 1.
- R10: Writing 1 to bit n at 0x41C clears the edge status of pin n. Zero bits leave status unchanged, and an edge status bit stays set until it is cleared. Reads of 0x41C return 0.
- R11: A spare register at 0x420 can be written and read back and has no effect on the pins or interrupts. Reads of unmapped addresses return 0.
- R12: An input change reaches the edge status on the third rising clock edge after it is applied. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address |
| pwdata_i | input | 8 | Write data |
| prdata_o | output | 8 | Read data (combinational, zero when not reading) |
| pin_i | input | 8 | Pad input values |
| pin_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume three things about the inputs.
- Bus accesses follow the two-phase select-then-enable order, and a write is committed on the enable cycle.
- Pad inputs are held steady through reset.
- An edge status bit can only appear after the synchronised input has changed.

The bench keeps to these assumptions. It drives every bus signal and pad on the falling clock edge, keeps the pads low through reset, and uses complete setup and access phases for each transfer. It holds each pad level for several cycles, so the synchroniser never sees a pulse shorter than one clock.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned PINS   = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  // word indices (byte address >> 2)
  localparam logic [IDX_W-1:0] IDX_DIR   = 10'h100;
  localparam logic [IDX_W-1:0] IDX_LEVEL = 10'h101;
  localparam logic [IDX_W-1:0] IDX_ANY   = 10'h102;
  localparam logic [IDX_W-1:0] IDX_POL   = 10'h103;
  localparam logic [IDX_W-1:0] IDX_EN    = 10'h104;
  localparam logic [IDX_W-1:0] IDX_RAW   = 10'h105;
  localparam logic [IDX_W-1:0] IDX_MSK   = 10'h106;
  localparam logic [IDX_W-1:0] IDX_CLR   = 10'h107;
  localparam logic [IDX_W-1:0] IDX_SPARE = 10'h108;

  typedef struct packed {
    logic [PINS-1:0] level;
    logic [PINS-1:0] any_edge;
    logic [PINS-1:0] pol;
  } trig_cfg_t;
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio8_irq_cell.sv
module gpio8_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic level_i,
  input  logic any_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q, edge_q;
  logic rise, fall, hit;

  assign rise = s_i & ~prev_q;
  assign fall = ~s_i & prev_q;
  assign hit  = any_i ? (rise | fall) : (pol_i ? rise : fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= s_i;
      // a new edge wins over a simultaneous clear
      if (!level_i && hit) edge_q <= 1'b1;
      else if (clr_i)      edge_q <= 1'b0;
    end
  end

  assign raw_o = level_i ? ~(s_i ^ pol_i) : edge_q;

  p_edge_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q && !clr_i |=> edge_q);

  p_edge_needs_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_q) |-> $past(s_i != prev_q));
endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [PINS-1:0]   pwdata_i,
  output logic [PINS-1:0]   prdata_o,
  input  logic [PINS-1:0]   sync_i,
  input  logic [PINS-1:0]   raw_i,
  output logic [PINS-1:0]   dir_o,
  output logic [PINS-1:0]   out_o,
  output trig_cfg_t         cfg_o,
  output logic [PINS-1:0]   en_o,
  output logic [PINS-1:0]   clr_o
);
  localparam int unsigned MSB_SEL = PINS + 2;

  logic [PINS-1:0]  dir_q, out_q, level_q, any_q, pol_q, en_q, spare_q;
  logic [IDX_W-1:0] idx;
  logic [PINS-1:0]  amask, pin_val, rd_mux;
  logic             in_data, wr, rd;

  assign idx     = paddr_i[ADDR_W-1:2];
  assign amask   = paddr_i[PINS+1:2];
  assign in_data = (paddr_i[ADDR_W-1:MSB_SEL] == '0);
  assign wr      = psel_i & penable_i & pwrite_i;
  assign rd      = psel_i & ~pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      level_q <= '0;
      any_q   <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      spare_q <= '0;
    end else if (wr) begin
      if (in_data) out_q <= (out_q & ~amask) | (pwdata_i & amask);
      else begin
        unique case (idx)
          IDX_DIR:   dir_q   <= pwdata_i;
          IDX_LEVEL: level_q <= pwdata_i;
          IDX_ANY:   any_q   <= pwdata_i;
          IDX_POL:   pol_q   <= pwdata_i;
          IDX_EN:    en_q    <= pwdata_i;
          IDX_SPARE: spare_q <= pwdata_i;
          default: ;
        endcase
      end
    end
  end

  assign clr_o = (wr && !in_data && idx == IDX_CLR) ? pwdata_i : '0;

  // outputs read back what they drive, inputs the synchronised pad
  assign pin_val = (dir_q & out_q) | (~dir_q & sync_i);

  always_comb begin
    rd_mux = '0;
    if (in_data) rd_mux = pin_val & amask;
    else begin
      unique case (idx)
        IDX_DIR:   rd_mux = dir_q;
        IDX_LEVEL: rd_mux = level_q;
        IDX_ANY:   rd_mux = any_q;
        IDX_POL:   rd_mux = pol_q;
        IDX_EN:    rd_mux = en_q;
        IDX_RAW:   rd_mux = raw_i;
        IDX_MSK:   rd_mux = raw_i & en_q;
        IDX_SPARE: rd_mux = spare_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  assign prdata_o       = rd ? rd_mux : '0;
  assign dir_o          = dir_q;
  assign out_o          = out_q;
  assign en_o           = en_q;
  assign cfg_o.level    = level_q;
  assign cfg_o.any_edge = any_q;
  assign cfg_o.pol      = pol_q;

  p_data_wr_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && in_data) |=> (((out_q ^ $past(out_q)) & ~$past(amask)) == '0));

  p_data_rd_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && in_data) |-> ((prdata_o & ~amask) == '0));
endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
  import gpio8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [PINS-1:0]   pwdata_i,
  output logic [PINS-1:0]   prdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_o
);
  logic [PINS-1:0] sync_v, raw_v, dir_v, out_v, en_v, clr_v;
  trig_cfg_t       cfg;

  gpio8_sync #(.WIDTH(PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_v)
  );

  gpio8_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .sync_i   (sync_v),
    .raw_i    (raw_v),
    .dir_o    (dir_v),
    .out_o    (out_v),
    .cfg_o    (cfg),
    .en_o     (en_v),
    .clr_o    (clr_v)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_cell
    gpio8_irq_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .s_i    (sync_v[n]),
      .level_i(cfg.level[n]),
      .any_i  (cfg.any_edge[n]),
      .pol_i  (cfg.pol[n]),
      .clr_i  (clr_v[n]),
      .raw_o  (raw_v[n])
    );
  end

  assign pin_o    = out_v;
  assign pin_oe_o = dir_v;
  assign irq_o    = |(raw_v & en_v);

  p_irq_needs_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_v == '0) |-> !irq_o);

  p_oe_only_by_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(pin_oe_o));
endmodule

// File: tb/gpio8_ctrl_bench.sv
module gpio8_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pin_in, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio8_ctrl u_gpio8_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // {address mask, write data, expected full port value}
  localparam logic [23:0] VEC [8] = '{
    {8'hFF, 8'hA5, 8'hA5}, {8'h0F, 8'hFF, 8'hAF},
    {8'h80, 8'h00, 8'h2F}, {8'h01, 8'h00, 8'h2E},
    {8'h3C, 8'hC3, 8'h02}, {8'hAA, 8'hFF, 8'hAA},
    {8'h55, 8'h55, 8'hFF}, {8'hFF, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rv;
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    bus_rd(12'h400, rv); check("R1 dir", rv, 8'h00);
    bus_rd(12'h404, rv); check("R1 level", rv, 8'h00);
    bus_rd(12'h410, rv); check("R1 en", rv, 8'h00);
    bus_rd(12'h420, rv); check("R1 spare", rv, 8'h00);

    // R4 direction
    bus_wr(12'h400, 8'hFF);
    check("R4 oe", pin_oe, 8'hFF);
    bus_rd(12'h400, rv); check("R4 dir rd", rv, 8'hFF);

    // R3/R2 masked data window, table driven
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m, w, e;
      {m, w, e} = VEC[i];
      bus_wr({2'b00, m, 2'b00}, w);
      check("R3 pin_o", pin_out, e);
      bus_rd(12'h3FC, rv); check("R2 full read", rv, e);
      bus_rd({2'b00, m, 2'b00}, rv); check("R2 masked read", rv, e & m);
    end

    // R2 input pins read synchronised pad
    bus_wr(12'h3FC, 8'h0A);
    bus_wr(12'h400, 8'h0F);
    check("R4 oe half", pin_oe, 8'h0F);
    pin_in = 8'hF0;
    settle();
    bus_rd(12'h3FC, rv); check("R2 mixed", rv, 8'hFA);
    bus_rd(12'h0C0, rv); check("R2 in mask", rv, 8'h30);

    // interrupts: pin0 rise, pin1 fall, pin2 any, pin3 high, pin4 low
    bus_wr(12'h400, 8'h00);
    pin_in = 8'h00;
    settle();
    bus_wr(12'h404, 8'h18);
    bus_wr(12'h408, 8'h04);
    bus_wr(12'h40C, 8'h09);
    bus_wr(12'h41C, 8'hFF);
    bus_rd(12'h414, rv); check("R8 low level", rv, 8'h10);
    pin_in = 8'h1F;
    settle();
    bus_rd(12'h414, rv); check("R5 R6 R7 R8 after rise", rv, 8'h0D);
    pin_in = 8'h00;
    settle();
    bus_rd(12'h414, rv); check("R6 R7 R10 after fall", rv, 8'h17);
    bus_rd(12'h41C, rv); check("R10 clr reads 0", rv, 8'h00);

    // R9 masking
    check("R9 irq off", {7'd0, irq}, 8'h00);
    bus_wr(12'h410, 8'h02);
    bus_rd(12'h418, rv); check("R9 masked", rv, 8'h02);
    check("R9 irq on", {7'd0, irq}, 8'h01);
    bus_wr(12'h410, 8'h00);
    check("R9 irq masked off", {7'd0, irq}, 8'h00);

    // R10 write-one-to-clear
    bus_wr(12'h41C, 8'h01);
    bus_rd(12'h414, rv); check("R10 clr one", rv, 8'h16);
    bus_wr(12'h41C, 8'h00);
    bus_rd(12'h414, rv); check("R10 zero no effect", rv, 8'h16);
    bus_wr(12'h41C, 8'h18);
    bus_rd(12'h414, rv); check("R8 level not cleared", rv, 8'h16);
    bus_wr(12'h41C, 8'h06);
    bus_rd(12'h414, rv); check("R10 clr rest", rv, 8'h10);

    // R12 latency through synchroniser
    bus_wr(12'h410, 8'h01);
    check("R12 idle", {7'd0, irq}, 8'h00);
    @(negedge clk);
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R12 not after 2", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R12 after 3", {7'd0, irq}, 8'h01);

    // R11 spare register and unmapped reads
    bus_wr(12'h420, 8'h5A);
    bus_rd(12'h420, rv); check("R11 spare", rv, 8'h5A);
    check("R11 oe", pin_oe, 8'h00);
    check("R11 out", pin_out, 8'h0A);
    check("R11 irq", {7'd0, irq}, 8'h01);
    bus_rd(12'h800, rv); check("R11 unmapped", rv, 8'h00);
    bus_rd(12'h424, rv); check("R11 unmapped2", rv, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule